// File: doc/BRIEF.md
# Keyed Window Watchdog

This block is a window watchdog serviced by a host that writes an 8-bit key through a simple register write/read port. In the key-advance mode, every accepted service must carry the next state of an 8-bit LFSR of the current key, and that value becomes the new key. In the echo mode, the host writes the current key back unchanged. After the watchdog is enabled, the first service may come at any point in a first-update window. After that, a closed window and an open window alternate. A service in the closed window, a wrong key, or a missed open window drives the reset output for a selectable hold time. Once the lock bit is set, the configuration cannot be changed until the next reset.

The register map uses a 3-bit address. Address 0 is the prescale register: bit 6 selects the mode (0 for key-advance, 1 for echo), and bits 5:0 hold the divider D. Address 1 is the window register: bits 7:4 hold the closed length C and bits 3:0 hold the open length O. Address 2 is the control register: bit 3 is the enable and bits 2:0 hold the first-update length F. Address 3 is the key. Address 4 is the lock register, bit 0. Address 5 is the hold register, bits 1:0. A unit of time is (D+1)·TICK_CYC clock cycles.

The controller has five states:
- OFF: the watchdog is disabled.
- FIRST: the first-update window.
- CLOSED: servicing is forbidden.
- OPEN: servicing is expected.
- HOLD: the reset output is driven.

Its transitions are:
- enable: OFF → FIRST.
- good service: FIRST/OPEN → CLOSED.
- bad service: FIRST/OPEN → HOLD.
- early service: CLOSED → HOLD.
- closed expiry: CLOSED → OPEN.
- window expiry: FIRST/OPEN → HOLD.
- hold done: HOLD → FIRST when enabled, otherwise HOLD → OFF.
- disable: FIRST/CLOSED/OPEN → OFF.

Top module: `kwd_top`

## Requirements
- R1: After reset, the reset output is low, the key reads the seed 0xA5, and the control and prescale registers read 0.
- R2: In key-advance mode (prescale bit 6 = 0), the only good service value is {key[6:0], key[7]^key[5]^key[4]^key[3]}. An accepted service makes the key read that value.
- R3: In echo mode (prescale bit 6 = 1), the only good service value is the current key, and an accepted service leaves the key unchanged.
- R4: After enable (control bit 3), a good service anywhere in the first-update window is accepted without reset. If no service arrives, reset rises once that window of F+1 units ends.
- R5: Any key write during the closed window starts a reset, and it does not change the key.
- R6: A wrong key written in the first-update or open window starts a reset, and it does not change the key.
- R7: If no service arrives before the open window expires, a reset starts. The combined closed and open period after a service lasts (C+1)+(O+1) units.
- R8: One unit is (D+1)·TICK_CYC clock cycles, and every window is measured from its own first cycle.
- R9: Hold code 0/1/2/3 (hold register bits 1:0) holds the reset for 1, 8·MS_CYC, 16·MS_CYC or 32·MS_CYC cycles respectively.
- R10: Setting lock bit 0 makes the prescale, window, control and hold registers read-only. The lock stays set until reset.
- R11: When the hold ends, the watchdog re-enters the first-update window if it is enabled. Clearing the enable stops it without a reset, and key writes while it is off are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| wdog_rst | output | 1 | Watchdog reset output, active high |

## Verification
The bench builds the block with TICK_CYC = 4 and MS_CYC = 2. This makes a unit four cycles and the longest hold 64 cycles. With these values, every window expiry and every hold code can be counted exactly in cycles within a short run. A divider of 1 is also programmed during the run, which doubles the unit and checks how the prescaler scales the combined window length.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [2:0] {
        WD_OFF, WD_FIRST, WD_CLOSED, WD_OPEN, WD_HOLD
    } wd_state_e;

    localparam logic [2:0] A_PRESC = 3'd0;
    localparam logic [2:0] A_WIN   = 3'd1;
    localparam logic [2:0] A_CTRL  = 3'd2;
    localparam logic [2:0] A_KEY   = 3'd3;
    localparam logic [2:0] A_LOCK  = 3'd4;
    localparam logic [2:0] A_HOLD  = 3'd5;

    function automatic logic [7:0] key_step(input logic [7:0] k);
        return {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
    endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       mode_echo,
    output logic [5:0] div,
    output logic [3:0] closed_len,
    output logic [3:0] open_len,
    output logic       enable,
    output logic [2:0] first_len,
    output logic [1:0] hold_code,
    output logic       locked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_echo  <= 1'b0;
            div        <= '0;
            closed_len <= '0;
            open_len   <= '0;
            enable     <= 1'b0;
            first_len  <= '0;
            hold_code  <= '0;
            locked     <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_LOCK) begin
                if (wr_data[0]) locked <= 1'b1;
            end else if (!locked) begin
                unique case (wr_addr)
                    A_PRESC: begin
                        mode_echo <= wr_data[6];
                        div       <= wr_data[5:0];
                    end
                    A_WIN: begin
                        closed_len <= wr_data[7:4];
                        open_len   <= wr_data[3:0];
                    end
                    A_CTRL: begin
                        enable    <= wr_data[3];
                        first_len <= wr_data[2:0];
                    end
                    A_HOLD: hold_code <= wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    // R10
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable({mode_echo, div, closed_len, open_len, enable,
                             first_len, hold_code}) && locked));
endmodule

// File: rtl/kwd_tick.sv
module kwd_tick #(
    parameter int TICK_CYC = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [5:0] div,
    output logic       unit_tick
);
    localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [TW-1:0] tick_cnt;
    logic [5:0]    div_cnt;
    logic          base;

    assign base      = (tick_cnt == TW'(TICK_CYC - 1));
    assign unit_tick = base && (div_cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            div_cnt  <= '0;
        end else if (restart) begin
            tick_cnt <= '0;
            div_cnt  <= '0;
        end else begin
            tick_cnt <= base ? '0 : tick_cnt + 1'b1;
            if (base) div_cnt <= (div_cnt == div) ? '0 : div_cnt + 1'b1;
        end
    end

    // R8
    restart_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && TICK_CYC > 1) |=> !unit_tick);
endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
#(
    parameter int         MS_CYC   = 50000,
    parameter logic [7:0] KEY_SEED = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       mode_echo,
    input  logic [3:0] closed_len,
    input  logic [3:0] open_len,
    input  logic [2:0] first_len,
    input  logic [1:0] hold_code,
    input  logic       unit_tick,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic [7:0] key_q,
    output logic       restart,
    output logic       wdog_rst
);
    localparam int HW = $clog2(32 * MS_CYC + 1);

    wd_state_e     state_q, state_d;
    logic [4:0]    win_cnt;
    logic [HW-1:0] hold_cnt;
    logic          key_ok, expire;

    function automatic logic [HW-1:0] hold_cycles(input logic [1:0] c);
        unique case (c)
            2'd0:    return HW'(1);
            2'd1:    return HW'(8 * MS_CYC);
            2'd2:    return HW'(16 * MS_CYC);
            default: return HW'(32 * MS_CYC);
        endcase
    endfunction

    assign key_ok  = mode_echo ? (key_data == key_q) : (key_data == key_step(key_q));
    assign expire  = unit_tick && (win_cnt == 5'd1);
    assign restart = (state_d != state_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:    if (enable) state_d = WD_FIRST;
            WD_FIRST, WD_OPEN: begin
                if (!enable)     state_d = WD_OFF;
                else if (key_wr) state_d = key_ok ? WD_CLOSED : WD_HOLD;
                else if (expire) state_d = WD_HOLD;
            end
            WD_CLOSED: begin
                if (!enable)     state_d = WD_OFF;
                else if (key_wr) state_d = WD_HOLD;
                else if (expire) state_d = WD_OPEN;
            end
            WD_HOLD:   if (hold_cnt == '0) state_d = enable ? WD_FIRST : WD_OFF;
            default:   state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            hold_cnt <= '0;
            key_q    <= KEY_SEED;
        end else begin
            if (restart) begin
                unique case (state_d)
                    WD_FIRST:  win_cnt <= {2'b00, first_len} + 5'd1;
                    WD_CLOSED: win_cnt <= {1'b0, closed_len} + 5'd1;
                    WD_OPEN:   win_cnt <= {1'b0, open_len} + 5'd1;
                    default:   win_cnt <= '0;
                endcase
            end else if (unit_tick && win_cnt > 5'd1) begin
                win_cnt <= win_cnt - 5'd1;
            end
            if (restart && state_d == WD_HOLD)      hold_cnt <= hold_cycles(hold_code) - 1'b1;
            else if (state_q == WD_HOLD && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
            if ((state_q == WD_FIRST || state_q == WD_OPEN) && enable &&
                key_wr && key_ok && !mode_echo)
                key_q <= key_data;
        end
    end

    always_comb wdog_rst = (state_q == WD_HOLD);

    // R5
    closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_CLOSED && enable && key_wr) |=> wdog_rst);
    // R6
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WD_FIRST || state_q == WD_OPEN) && enable && key_wr &&
         key_data != key_q && key_data != key_step(key_q)) |=> wdog_rst);
    // R2
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(key_q));
    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_OFF) |=> !wdog_rst);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int         TICK_CYC = 500,
    parameter int         MS_CYC   = 50000,
    parameter logic [7:0] KEY_SEED = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       wdog_rst
);
    logic       mode_echo, enable, locked, unit_tick, restart;
    logic [5:0] div;
    logic [3:0] closed_len, open_len;
    logic [2:0] first_len;
    logic [1:0] hold_code;
    logic [7:0] key_q;
    logic       key_wr;

    assign key_wr = wr_en && (wr_addr == A_KEY);

    kwd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_echo(mode_echo), .div(div), .closed_len(closed_len), .open_len(open_len),
        .enable(enable), .first_len(first_len), .hold_code(hold_code), .locked(locked)
    );

    kwd_tick #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(div), .unit_tick(unit_tick)
    );

    kwd_fsm #(.MS_CYC(MS_CYC), .KEY_SEED(KEY_SEED)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_echo(mode_echo),
        .closed_len(closed_len), .open_len(open_len), .first_len(first_len),
        .hold_code(hold_code), .unit_tick(unit_tick), .key_wr(key_wr),
        .key_data(wr_data), .key_q(key_q), .restart(restart), .wdog_rst(wdog_rst)
    );

    always_comb begin
        unique case (rd_addr)
            A_PRESC: rd_data = {1'b0, mode_echo, div};
            A_WIN:   rd_data = {closed_len, open_len};
            A_CTRL:  rd_data = {4'b0, enable, first_len};
            A_KEY:   rd_data = key_q;
            A_LOCK:  rd_data = {7'b0, locked};
            A_HOLD:  rd_data = {6'b0, hold_code};
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: tb/kwd_top_tb_top.sv
module kwd_top_tb_top;
    localparam int TICK_CYC = 4;
    localparam int MS_CYC   = 2;

    typedef struct {
        string req;
        int    act;
        int    exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wdog_rst;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    kwd_top #(.TICK_CYC(TICK_CYC), .MS_CYC(MS_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdog_rst(wdog_rst)
    );

    function automatic logic [7:0] nxt(input logic [7:0] k);
        return {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
    endfunction

    task automatic push(input string req, input int act, input int exp);
        item_t it;
        it.req = req; it.act = act; it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor: pops expectations and compares
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.act != it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%0d expected=%0d", it.req, it.act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic count_level(input logic v, output int n);
        n = 0;
        while (wdog_rst == v && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, key;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        push("R1 rst low", int'(wdog_rst), 0);
        rd(3'd3, v); push("R1 key seed", int'(v), 8'hA5);
        rd(3'd2, v); push("R1 ctrl zero", int'(v), 0);
        rd(3'd0, v); push("R1 presc zero", int'(v), 0);
        key = 8'hA5;

        wr(3'd1, 8'h13);      // closed 2 units, open 4 units
        wr(3'd5, 8'h01);      // hold code 1
        wr(3'd2, 8'h0A);      // enable, first 3 units
        repeat (3) @(negedge clk);
        key = nxt(key);
        wr(3'd3, key);        // R4 good service in first window
        push("R4 no rst on first service", int'(wdog_rst), 0);
        rd(3'd3, v); push("R2 key advanced", int'(v), int'(key));

        repeat (10) @(negedge clk);   // now inside open window
        key = nxt(key);
        wr(3'd3, key);
        push("R2 open service no rst", int'(wdog_rst), 0);
        rd(3'd3, v); push("R2 key advanced again", int'(v), int'(key));

        repeat (2) @(negedge clk);
        wr(3'd3, nxt(key));   // R5 write in closed window
        count_level(1'b1, n); push("R9 hold code1 cycles", n, 8 * MS_CYC);
        rd(3'd3, v); push("R5 key unchanged", int'(v), int'(key));

        // now in first window again (R11)
        wr(3'd5, 8'h00);
        wr(3'd3, 8'h00);      // R6 wrong key
        count_level(1'b1, n); push("R9 hold code0 cycles", n, 1);
        count_level(1'b0, n); push("R4 first window expiry", n, 3 * TICK_CYC);
        wr(3'd5, 8'h02);
        rd(3'd3, v); push("R6 key unchanged", int'(v), int'(key));
        key = nxt(key);
        wr(3'd3, key);
        count_level(1'b0, n); push("R7 closed+open expiry", n, (2 + 4) * TICK_CYC);
        count_level(1'b1, n); push("R9 hold code2 cycles", n, 16 * MS_CYC);

        wr(3'd0, 8'h41);      // echo mode, div 1
        wr(3'd3, key);        // R3 echo service
        count_level(1'b0, n); push("R8 scaled window length", n, (2 + 4) * 2 * TICK_CYC);
        rd(3'd3, v); push("R3 key unchanged", int'(v), int'(key));
        count_level(1'b1, n); push("R9 hold code2 again", n, 16 * MS_CYC);

        wr(3'd2, 8'h02);      // R11 disable
        repeat (60) @(negedge clk);
        push("R11 off no rst", int'(wdog_rst), 0);
        wr(3'd3, 8'h55);
        rd(3'd3, v); push("R11 key write ignored when off", int'(v), int'(key));

        wr(3'd4, 8'h01);      // R10 lock
        wr(3'd2, 8'h0A);
        rd(3'd2, v); push("R10 ctrl frozen", int'(v), 8'h02);
        wr(3'd4, 8'h00);
        rd(3'd4, v); push("R10 lock sticky", int'(v), 1);
        repeat (60) @(negedge clk);
        push("R10 stays off", int'(wdog_rst), 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule